// File: doc/BRIEF.md
# Latched Fault Status and Interrupt Controller

This block sits beside the switches of a hot-plug power controller and turns raw protection events into sticky status. Per-rail undervoltage flags, fast and slow overcurrent trips for a main and an auxiliary rail, a slot over-temperature flag and a global die over-temperature flag are classified into five fault bits. A fault bit can latch only while its enable source is active. In register-control mode the source is the two output-enable bits of the control register. In pin-control mode it is the external ON and AUXEN pins. Software acknowledges a fault by writing a one back to the bit that reported it. Zeros in that write leave the bits alone.

Faults are reported in three ways. Software can poll the registers. An active-low interrupt can be unmasked. In pin-control mode, an active-low FAULT output holds until both enable pins drop. A slow overcurrent trip only counts once a filter counter has run out, or at once when the slot is hot. An active-low FORCE_ON pin is a diagnostic override. While it is honoured, all protection and reporting is suspended. A control bit can lock it out. The mode is chosen by a strap pin that is sampled while reset is held.

Top module: `pwr_fault_mon`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, every latched fault bit and the control register read 0, the mask bit reads 1, and irq_n and fault_n are high. The registers are at reg_addr 0 (STATUS), 1 (CTRL) and 2 (CS).
- R2: mode_strap is captured only while rst_n is low. A capture of 1 selects pin-control mode and 0 selects register-control mode.
- R3: Faults latch one clock after they are present, with this mapping. A rail flag in uv_low sets STATUS[4]. A main-rail trip (oc_fast[0], or a qualified oc_slow[0]) sets STATUS[0]. An auxiliary trip on channel 1 sets STATUS[2]. die_hot sets CS[2]. slot_hot together with any slow trip sets CS[1], and it also sets the OC bit of that channel.
- R4: In register-control mode, no fault bit latches while CTRL[1:0] is 00. In pin-control mode, no fault bit latches while on_pin and auxen_pin are both low.
- R5: A slow trip with slot_hot low sets its OC bit only after the trip has been high for SLOW_LIMIT+1 consecutive clocks. A trip that drops earlier restarts the count.
- R6: Writing a 1 to STATUS[0], STATUS[2], STATUS[4], CS[1] or CS[2] clears that bit, and writing a 0 leaves it unchanged. If a set condition and the clearing write fall in the same cycle, the bit stays set.
- R7: With CS[3] written to 0, irq_n is low whenever any latched fault bit is 1. It returns high once the bits are cleared.
- R8: With CS[3] at 1, irq_n stays high and the latched bits remain readable.
- R9: In register-control mode, fault_n stays high and STATUS[7] reads 0.
- R10: In pin-control mode, fault_n goes low one clock after a fault is present while on_pin or auxen_pin is high. It stays low after the fault goes away, and it goes high one clock after both pins are low. STATUS[7] reads 1 exactly while fault_n is low.
- R11: force_n low is honoured only while CTRL[2] is 0. While honoured, no fault bit latches and fault_n goes high one clock later. With CTRL[2] at 1, force_n has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 1 | Mode strap, 1 = pin control, sampled in reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 STATUS, 1 CTRL, 2 CS |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| uv_low | input | NUM_UV | Per-rail undervoltage flags |
| oc_fast | input | 2 | Fast overcurrent trips (0 main, 1 aux) |
| oc_slow | input | 2 | Slow overcurrent trips (0 main, 1 aux) |
| slot_hot | input | 1 | Slot over-temperature flag |
| die_hot | input | 1 | Global over-temperature flag |
| on_pin | input | 1 | External main enable |
| auxen_pin | input | 1 | External auxiliary enable |
| force_n | input | 1 | Active-low diagnostic override |
| irq_n | output | 1 | Active-low interrupt |
| fault_n | output | 1 | Active-low fault output |

## Verification
The assertions check several properties on every cycle. The echo clear and the stickiness of the main overcurrent bit are checked, and so is the ban on latching while the control enables are off. The register-mode silence of fault_n, the release of fault_n when the enable pins drop, the override by force_n, and the quieting of irq_n by a mask write are also checked cycle by cycle. Only the bench scenarios can show the full set of bit mappings and the exact length of the slow filter window with its restart. The same holds for the set-over-clear priority, the strap capture and the lock-out of the override by CTRL[2].

// File: rtl/pfm_pkg.sv
package pfm_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        A_STAT = 2'd0,
        A_CTRL = 2'd1,
        A_CS   = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic oc_main;
        logic oc_aux;
        logic uv;
        logic hot_slot;
        logic hot_die;
    } evt_t;

    typedef struct packed {
        logic       pin_mode;
        logic [2:0] ctrl;
        logic       mask;
        logic       oc_main;
        logic       oc_aux;
        logic       uv;
        logic       hot_slot;
        logic       hot_die;
        logic       fault;
    } state_t;
endpackage

// File: rtl/pfm_slow_filter.sv
module pfm_slow_filter #(
    parameter int LIMIT = 20,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic trip,
    output logic expired
);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !trip) begin
            cnt_d = '0;
        end else if (cnt_q != LIM_C) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM_C);
endmodule

// File: rtl/pfm_fault_eval.sv
module pfm_fault_eval
    import pfm_pkg::*;
#(
    parameter int NUM_UV = 3
) (
    input  logic [NUM_UV-1:0] uv_low,
    input  logic [NUM_CH-1:0] oc_fast,
    input  logic [NUM_CH-1:0] oc_slow,
    input  logic [NUM_CH-1:0] slow_expired,
    input  logic              slot_hot,
    input  logic              die_hot,
    output evt_t              evt
);
    logic [NUM_CH-1:0] ch_trip;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            ch_trip[c] = oc_fast[c]
                       | (oc_slow[c] & slow_expired[c])
                       | (oc_slow[c] & slot_hot);
        end
        evt.oc_main  = ch_trip[0];
        evt.oc_aux   = ch_trip[1];
        evt.uv       = |uv_low;
        evt.hot_slot = slot_hot & (|oc_slow);
        evt.hot_die  = die_hot;
    end
endmodule

// File: rtl/pwr_fault_mon.sv
module pwr_fault_mon
    import pfm_pkg::*;
#(
    parameter int NUM_UV     = 3,
    parameter int SLOW_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [NUM_UV-1:0] uv_low,
    input  logic [1:0]        oc_fast,
    input  logic [1:0]        oc_slow,
    input  logic              slot_hot,
    input  logic              die_hot,
    input  logic              on_pin,
    input  logic              auxen_pin,
    input  logic              force_n,
    output logic              irq_n,
    output logic              fault_n
);
    state_t            state_d, state_q;
    evt_t              evt;
    logic [NUM_CH-1:0] slow_expired;
    logic              force_on;
    logic              pins_en;
    logic              arm;
    logic              wr_stat, wr_ctrl, wr_cs;

    assign force_on = ~force_n & ~state_q.ctrl[2];
    assign pins_en  = on_pin | auxen_pin;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_filt
        pfm_slow_filter #(.LIMIT(SLOW_LIMIT)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (force_on),
            .trip    (oc_slow[c]),
            .expired (slow_expired[c])
        );
    end

    pfm_fault_eval #(.NUM_UV(NUM_UV)) u_eval (
        .uv_low       (uv_low),
        .oc_fast      (oc_fast),
        .oc_slow      (oc_slow),
        .slow_expired (slow_expired),
        .slot_hot     (slot_hot),
        .die_hot      (die_hot),
        .evt          (evt)
    );

    always_comb begin
        wr_stat = reg_wr && (reg_addr == A_STAT);
        wr_ctrl = reg_wr && (reg_addr == A_CTRL);
        wr_cs   = reg_wr && (reg_addr == A_CS);
        arm     = (state_q.pin_mode ? pins_en : |state_q.ctrl[1:0]) & ~force_on;

        state_d = state_q;
        if (wr_ctrl) state_d.ctrl = reg_wdata[2:0];
        if (wr_cs)   state_d.mask = reg_wdata[3];

        if (wr_stat) begin
            state_d.oc_main = state_d.oc_main & ~reg_wdata[0];
            state_d.oc_aux  = state_d.oc_aux  & ~reg_wdata[2];
            state_d.uv      = state_d.uv      & ~reg_wdata[4];
        end
        if (wr_cs) begin
            state_d.hot_slot = state_d.hot_slot & ~reg_wdata[1];
            state_d.hot_die  = state_d.hot_die  & ~reg_wdata[2];
        end

        if (arm) begin
            state_d.oc_main  = state_d.oc_main  | evt.oc_main;
            state_d.oc_aux   = state_d.oc_aux   | evt.oc_aux;
            state_d.uv       = state_d.uv       | evt.uv;
            state_d.hot_slot = state_d.hot_slot | evt.hot_slot;
            state_d.hot_die  = state_d.hot_die  | evt.hot_die;
        end

        if (state_q.pin_mode) begin
            state_d.fault = (state_q.fault | (arm & (|evt))) & pins_en & ~force_on;
        end else begin
            state_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.mask     <= 1'b1;
            state_q.pin_mode <= mode_strap;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_STAT:  reg_rdata = {state_q.fault, 2'b00, state_q.uv, 1'b0,
                                  state_q.oc_aux, 1'b0, state_q.oc_main};
            A_CTRL:  reg_rdata = {5'b0, state_q.ctrl};
            A_CS:    reg_rdata = {4'b0, state_q.mask, state_q.hot_die,
                                  state_q.hot_slot, 1'b0};
            default: reg_rdata = 8'h00;
        endcase
    end

    assign irq_n   = ~(~state_q.mask & (state_q.oc_main | state_q.oc_aux | state_q.uv
                                        | state_q.hot_slot | state_q.hot_die));
    assign fault_n = ~state_q.fault;
endmodule

// File: rtl/pfm_checker.sv
module pfm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic       wd0,
    input logic       wd3,
    input logic       force_n,
    input logic       on_pin,
    input logic       auxen_pin,
    input logic       irq_n,
    input logic       fault_n,
    input logic       pin_mode,
    input logic [2:0] ctrl,
    input logic       st_main,
    input logic       st_uv,
    input logic       evt_main
);
    a_r9_regmode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_mode |-> fault_n);

    a_r8_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2 && wd3) |=> irq_n);

    a_r6_echo_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && wd0 && !evt_main) |=> !st_main);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_main && !(reg_wr && reg_addr == 2'd0 && wd0)) |=> st_main);

    a_r4_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_mode && ctrl[1:0] == 2'b00 && !st_uv) |=> !st_uv);

    a_r11_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_n && !ctrl[2]) |=> fault_n);

    a_r10_pins_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && !on_pin && !auxen_pin) |=> fault_n);
endmodule

bind pwr_fault_mon pfm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wd0       (reg_wdata[0]),
    .wd3       (reg_wdata[3]),
    .force_n   (force_n),
    .on_pin    (on_pin),
    .auxen_pin (auxen_pin),
    .irq_n     (irq_n),
    .fault_n   (fault_n),
    .pin_mode  (state_q.pin_mode),
    .ctrl      (state_q.ctrl),
    .st_main   (state_q.oc_main),
    .st_uv     (state_q.uv),
    .evt_main  (evt.oc_main)
);

// File: tb/tb_pwr_fault_mon.sv
module tb_pwr_fault_mon;
    localparam int LIM = 20;

    logic       clk = 1'b0;
    logic       rst_n, mode_strap, reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [2:0] uv_low;
    logic [1:0] oc_fast, oc_slow;
    logic       slot_hot, die_hot, on_pin, auxen_pin, force_n;
    logic       irq_n, fault_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwr_fault_mon #(.NUM_UV(3), .SLOW_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .uv_low(uv_low), .oc_fast(oc_fast),
        .oc_slow(oc_slow), .slot_hot(slot_hot), .die_hot(die_hot),
        .on_pin(on_pin), .auxen_pin(auxen_pin), .force_n(force_n),
        .irq_n(irq_n), .fault_n(fault_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        tick();
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0; mode_strap = strap; reg_wr = 1'b0; reg_addr = 2'd0;
        reg_wdata = 8'h00; uv_low = '0; oc_fast = '0; oc_slow = '0;
        slot_hot = 1'b0; die_hot = 1'b0; on_pin = 1'b0; auxen_pin = 1'b0;
        force_n = 1'b1;
        tick(3);
        rst_n = 1'b1;
        mode_strap = ~strap;
        tick();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset(1'b0);
        rd(2'd0, v); check("R1 status", v, 8'h00);
        rd(2'd1, v); check("R1 ctrl", v, 8'h00);
        rd(2'd2, v); check("R1 cs", v, 8'h08);
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);
        check("R1 fault_n", {7'b0, fault_n}, 8'h01);
    endtask

    task automatic t_gate();
        logic [7:0] v;
        uv_low = 3'b001; tick(2); uv_low = '0; tick();
        rd(2'd0, v); check("R4 gated off", v, 8'h00);
        wr(2'd1, 8'h02);
        uv_low = 3'b100; tick(); uv_low = '0; tick();
        rd(2'd0, v); check("R3 uv latch", v, 8'h10);
        wr(2'd0, 8'h10);
    endtask

    task automatic t_map();
        logic [7:0] v;
        wr(2'd1, 8'h03);
        oc_fast = 2'b01; tick(); oc_fast = '0; tick();
        rd(2'd0, v); check("R3 main oc", v, 8'h01);
        wr(2'd0, 8'h01);
        oc_fast = 2'b10; tick(); oc_fast = '0;
        rd(2'd0, v); check("R3 aux oc", v, 8'h04);
        wr(2'd0, 8'h04);
        die_hot = 1'b1; tick(); die_hot = 1'b0;
        rd(2'd2, v); check("R3 die hot", v, 8'h0C);
        wr(2'd2, 8'h0C);
        slot_hot = 1'b1; oc_slow = 2'b10; tick(); slot_hot = 1'b0; oc_slow = '0;
        rd(2'd2, v); check("R3 slot hot cs", v, 8'h0A);
        rd(2'd0, v); check("R3 slot hot oc", v, 8'h04);
        check("R9 fault_n reg mode", {7'b0, fault_n}, 8'h01);
        wr(2'd0, 8'h04); wr(2'd2, 8'h0A);
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        oc_fast = 2'b11; uv_low = 3'b010; tick(); oc_fast = '0; uv_low = '0;
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R6 write zero", v, 8'h15);
        check("R9 status7 reg mode", {7'b0, v[7]}, 8'h00);
        wr(2'd0, 8'h04);
        rd(2'd0, v); check("R6 clear one", v, 8'h11);
        oc_fast = 2'b01; wr(2'd0, 8'h11); oc_fast = '0;
        rd(2'd0, v); check("R6 set wins", v, 8'h01);
        wr(2'd0, 8'h01);
        rd(2'd0, v); check("R6 cleared", v, 8'h00);
    endtask

    task automatic t_filter();
        logic [7:0] v;
        oc_slow = 2'b01; tick(LIM); oc_slow = '0; tick();
        rd(2'd0, v); check("R5 window not reached", v, 8'h00);
        oc_slow = 2'b01; tick(5); oc_slow = '0; tick();
        oc_slow = 2'b01; tick(LIM); oc_slow = '0; tick();
        rd(2'd0, v); check("R5 restart", v, 8'h00);
        oc_slow = 2'b01; tick(LIM + 1); oc_slow = '0;
        rd(2'd0, v); check("R5 expiry sets", v, 8'h01);
        wr(2'd0, 8'h01);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        oc_fast = 2'b01; tick(); oc_fast = '0;
        check("R8 masked irq_n", {7'b0, irq_n}, 8'h01);
        rd(2'd0, v); check("R8 readable", v, 8'h01);
        wr(2'd2, 8'h00);
        check("R7 irq low", {7'b0, irq_n}, 8'h00);
        wr(2'd0, 8'h01);
        check("R7 irq released", {7'b0, irq_n}, 8'h01);
        die_hot = 1'b1; tick(); die_hot = 1'b0;
        check("R7 irq on die hot", {7'b0, irq_n}, 8'h00);
        wr(2'd2, 8'h0C);
        check("R8 remask", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_pin();
        logic [7:0] v;
        do_reset(1'b1);
        uv_low = 3'b001; tick(); uv_low = '0;
        check("R4 pins off", {7'b0, fault_n}, 8'h01);
        rd(2'd0, v); check("R4 pins off status", v, 8'h00);
        on_pin = 1'b1; uv_low = 3'b001; tick(); uv_low = '0;
        check("R10 fault asserts", {7'b0, fault_n}, 8'h00);
        rd(2'd0, v); check("R2 R10 status7", v, 8'h90);
        on_pin = 1'b0; auxen_pin = 1'b1; tick(2);
        check("R10 fault holds", {7'b0, fault_n}, 8'h00);
        auxen_pin = 1'b0; tick();
        check("R10 fault clears", {7'b0, fault_n}, 8'h01);
        rd(2'd0, v); check("R10 status after", v, 8'h10);
        wr(2'd0, 8'h10);
    endtask

    task automatic t_force();
        logic [7:0] v;
        force_n = 1'b0; on_pin = 1'b1; uv_low = 3'b001; tick();
        check("R11 force blocks", {7'b0, fault_n}, 8'h01);
        rd(2'd0, v); check("R11 no latch", v, 8'h00);
        wr(2'd1, 8'h04);
        tick();
        check("R11 locked out", {7'b0, fault_n}, 8'h00);
        rd(2'd0, v); check("R11 latch when locked", v, 8'h90);
        wr(2'd1, 8'h00);
        uv_low = '0; tick();
        check("R11 force clears fault", {7'b0, fault_n}, 8'h01);
        force_n = 1'b1; on_pin = 1'b0;
    endtask

    initial begin
        #(5ns * 20000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_gate();
        t_map();
        t_w1c();
        t_filter();
        t_irq();
        t_pin();
        t_force();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule